// File: doc/BRIEF.md
# Over-Current Pulse-Skip Monitor

This block sits beside the PWM modulator of a synchronous buck regulator and acts once per switching cycle. A comparator elsewhere raises a current-limit-detect flag. The PWM oscillator supplies a one-clock strobe that marks the start of every switching cycle. When the flag is seen on a strobe, the monitor holds off the high-side switch for that cycle and for eight more. It then watches the next eight cycles. If the limit shows up again inside that window, it sends a single-clock fault request to the protection latch. If the window stays quiet, the monitor returns to idle.

While the soft-start ramp is still below its completion threshold, the skip behaviour is unchanged but fault requests are held back. Dropping the regulator enable, or asserting reset, returns the monitor to idle at once. The skip and watch lengths are parameters. The defaults are eight cycles each.

Top module: `oc_skip_monitor`

## Requirements
- R1: During and after a synchronous reset, `hs_inhibit` and `oc_fault` are 0, and the monitor is idle: a strobe with `lim_det` low produces no inhibit.
- R2: While idle, `lim_det` is looked at only in a clock where `cyc_start` is 1. If it is high there, `hs_inhibit` is 1 in that same clock and stays 1 through the following eight switching cycles. A `lim_det` pulse between strobes while idle causes neither inhibit nor fault.
- R3: Once a trip has occurred, `hs_inhibit` is 0 from the ninth strobe after the trip strobe onward, unless a new detection occurs.
- R4: A `lim_det` pulse during the eight skip cycles (strobes 1 to 8 after the trip and the clocks between them) raises no fault and does not lengthen the skip.
- R5: A `lim_det` high in any clock from strobe 9 up to, but not including, strobe 17 is a window hit. On a window hit, `oc_fault` is 1 in the next clock. `hs_inhibit` is 1 from that next clock, and a fresh eight-cycle skip begins.
- R6: If no hit occurs in the window, the monitor is idle again at strobe 17. A `lim_det` high on strobe 17 is then a fresh trip, with inhibit and with no fault.
- R7: A window hit in a clock where `ss_active` is 1 produces no `oc_fault`, but it still restarts the skip with inhibit.
- R8: With `enable` at 0, `hs_inhibit` is 0 and `oc_fault` is 0 from the next clock. A sequence in progress is abandoned, so the monitor is idle when `enable` returns.
- R9: `oc_fault` is never 1 in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Regulator enable; low forces idle |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| lim_det | input | 1 | Current-limit-detect flag from the comparator |
| ss_active | input | 1 | High while soft-start is below its completion level |
| hs_inhibit | output | 1 | Blocks the high-side drive for the current cycle |
| oc_fault | output | 1 | One-clock fault request to the protection latch |

## Verification
Two cases are the hardest to reach from the ports. The first is a detection on exactly the ninth or the sixteenth strobe after a trip. The second is the strobe that closes the window, where a detection must count as a fresh trip and not as a fault. Reaching them takes counting strobes precisely across seventeen switching cycles. The stimulus therefore describes whole switching cycles, each four clocks long, with a detection slot at the strobe and another in mid-cycle. Sequences are chained so that each ends exactly where the next boundary case begins: a mid-window hit, a clean window closing into a new trip, a suppressed hit at the window's first strobe and a hit at its last strobe.

// File: rtl/oc_mon_pkg.sv
package oc_mon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SKIP  = 2'd1,
        PH_WATCH = 2'd2
    } oc_phase_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_ZERO = 2'd1,
        CNT_ONE  = 2'd2,
        CNT_INC  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        oc_phase_e phase_next;
        cnt_op_e   cnt_op;
        logic      inhibit;
        logic      hit;
        logic      trip;
    } oc_step_t;

    function automatic int cnt_bits(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/oc_cycle_counter.sv
module oc_cycle_counter
    import oc_mon_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case (op)
                CNT_ZERO: count_q <= '0;
                CNT_ONE:  count_q <= CNT_W'(1);
                CNT_INC:  count_q <= count_q + CNT_W'(1);
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;

endmodule

// File: rtl/oc_phase_ctrl.sv
module oc_phase_ctrl
    import oc_mon_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8,
    parameter int CNT_W        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cyc_start,
    input  logic             lim_det,
    input  logic [CNT_W-1:0] count,
    output oc_phase_e        phase,
    output oc_step_t         step
);

    localparam logic [CNT_W-1:0] SKIP_LAST  = CNT_W'(SKIP_CYCLES);
    localparam logic [CNT_W-1:0] WATCH_LAST = CNT_W'(WATCH_CYCLES);

    oc_phase_e phase_q;
    oc_step_t  s;

    always_comb begin
        s.phase_next = phase_q;
        s.cnt_op     = CNT_HOLD;
        s.inhibit    = 1'b0;
        s.hit        = 1'b0;
        s.trip       = 1'b0;

        if (!enable) begin
            s.phase_next = PH_IDLE;
            s.cnt_op     = CNT_ZERO;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (cyc_start && lim_det) begin
                        s.trip       = 1'b1;
                        s.inhibit    = 1'b1;
                        s.phase_next = PH_SKIP;
                        s.cnt_op     = CNT_ZERO;
                    end
                end

                PH_SKIP: begin
                    s.inhibit = 1'b1;
                    if (cyc_start) begin
                        if (count == SKIP_LAST) begin
                            // this strobe opens the first watch cycle
                            if (lim_det) begin
                                s.hit        = 1'b1;
                                s.phase_next = PH_SKIP;
                                s.cnt_op     = CNT_ZERO;
                            end else begin
                                s.inhibit    = 1'b0;
                                s.phase_next = PH_WATCH;
                                s.cnt_op     = CNT_ONE;
                            end
                        end else begin
                            s.cnt_op = CNT_INC;
                        end
                    end
                end

                PH_WATCH: begin
                    if (cyc_start && (count == WATCH_LAST)) begin
                        // window over: this strobe behaves as idle
                        if (lim_det) begin
                            s.trip       = 1'b1;
                            s.inhibit    = 1'b1;
                            s.phase_next = PH_SKIP;
                        end else begin
                            s.phase_next = PH_IDLE;
                        end
                        s.cnt_op = CNT_ZERO;
                    end else if (lim_det) begin
                        s.hit        = 1'b1;
                        s.inhibit    = 1'b1;
                        s.phase_next = PH_SKIP;
                        s.cnt_op     = CNT_ZERO;
                    end else if (cyc_start) begin
                        s.cnt_op = CNT_INC;
                    end
                end

                default: begin
                    s.phase_next = PH_IDLE;
                    s.cnt_op     = CNT_ZERO;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= s.phase_next;
    end

    assign phase = phase_q;
    assign step  = s;

endmodule

// File: rtl/oc_fault_pulse.sv
module oc_fault_pulse (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic hit,
    input  logic ss_active,
    output logic fault
);

    logic fault_q;

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= enable & hit & ~ss_active;
    end

    assign fault = fault_q;

endmodule

// File: rtl/oc_skip_monitor.sv
module oc_skip_monitor
    import oc_mon_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cyc_start,
    input  logic lim_det,
    input  logic ss_active,
    output logic hs_inhibit,
    output logic oc_fault
);

    localparam int CNT_W = cnt_bits(max_of(SKIP_CYCLES, WATCH_CYCLES));

    logic [CNT_W-1:0] count;
    oc_phase_e        phase_q;
    oc_step_t         step;

    oc_phase_ctrl #(
        .SKIP_CYCLES (SKIP_CYCLES),
        .WATCH_CYCLES(WATCH_CYCLES),
        .CNT_W       (CNT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .cyc_start(cyc_start),
        .lim_det  (lim_det),
        .count    (count),
        .phase    (phase_q),
        .step     (step)
    );

    oc_cycle_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk  (clk),
        .rst  (rst),
        .op   (step.cnt_op),
        .count(count)
    );

    oc_fault_pulse fault_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .hit      (step.hit),
        .ss_active(ss_active),
        .fault    (oc_fault)
    );

    assign hs_inhibit = step.inhibit;

endmodule

// File: rtl/oc_skip_monitor_chk.sv
module oc_skip_monitor_chk
    import oc_mon_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      enable,
    input logic      cyc_start,
    input logic      lim_det,
    input logic      ss_active,
    input logic      hs_inhibit,
    input logic      oc_fault,
    input oc_phase_e phase
);

    assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !hs_inhibit)
        else $error("R8: inhibit while disabled");

    assert_disable_no_fault_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !oc_fault)
        else $error("R8: fault after disable");

    assert_fault_single_R9: assert property (@(posedge clk) disable iff (rst)
        oc_fault |=> !oc_fault)
        else $error("R9: fault longer than one clock");

    assert_ss_suppress_R7: assert property (@(posedge clk) disable iff (rst)
        ss_active |=> !oc_fault)
        else $error("R7: fault during soft-start");

    assert_idle_trip_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && enable && cyc_start && lim_det) |-> hs_inhibit)
        else $error("R2: trip without inhibit");

    assert_idle_midcycle_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !cyc_start) |-> !hs_inhibit)
        else $error("R2: inhibit from idle without strobe");

    assert_skip_no_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP && !cyc_start) |=> !oc_fault)
        else $error("R4: fault from skip cycle");

    assert_fault_restarts_R5: assert property (@(posedge clk) disable iff (rst)
        (oc_fault && enable) |-> hs_inhibit)
        else $error("R5: fault without restarted skip");

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (phase == PH_IDLE && !oc_fault))
        else $error("R1: not idle after reset");

endmodule

bind oc_skip_monitor oc_skip_monitor_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cyc_start (cyc_start),
    .lim_det   (lim_det),
    .ss_active (ss_active),
    .hs_inhibit(hs_inhibit),
    .oc_fault  (oc_fault),
    .phase     (phase_q)
);

// File: tb/oc_skip_monitor_tb_top.sv
module oc_skip_monitor_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic cyc_start = 1'b0;
    logic lim_det = 1'b0;
    logic ss_active = 1'b0;
    logic hs_inhibit;
    logic oc_fault;

    int n_checks = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    oc_skip_monitor dut_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cyc_start (cyc_start),
        .lim_det   (lim_det),
        .ss_active (ss_active),
        .hs_inhibit(hs_inhibit),
        .oc_fault  (oc_fault)
    );

    // one row per switching cycle of four clocks:
    // {ss, lim@strobe, lim@mid, inh@clk0, inh@clk1, inh@clk3, flt@clk1, flt@clk3}
    localparam int NV = 64;
    localparam logic [7:0] VEC [NV] = '{
        8'b01011100, 8'b00011100, 8'b00011100, 8'b01011100,  // 0..3 trip, R4 at 3
        8'b00011100, 8'b00111100, 8'b00011100, 8'b00011100,  // 4..7 R4 at 5
        8'b00011100, 8'b00000000, 8'b00000000, 8'b00000000,  // 8, watch opens at 9
        8'b00100101, 8'b00011100, 8'b00011100, 8'b00011100,  // 12 mid-window hit R5
        8'b00011100, 8'b00011100, 8'b00011100, 8'b00011100,
        8'b00011100, 8'b00000000, 8'b00000000, 8'b00000000,  // 21 watch opens
        8'b00000000, 8'b00000000, 8'b00000000, 8'b00000000,
        8'b00000000, 8'b01011100, 8'b00011100, 8'b00011100,  // 29 strobe 17 fresh trip R6
        8'b00011100, 8'b00011100, 8'b00011100, 8'b00011100,
        8'b00011100, 8'b00011100, 8'b11011100, 8'b00011100,  // 38 suppressed hit R7
        8'b00011100, 8'b00011100, 8'b00011100, 8'b00011100,
        8'b00011100, 8'b00011100, 8'b00011100, 8'b00000000,  // 47 watch opens
        8'b00000000, 8'b00000000, 8'b00000000, 8'b00000000,
        8'b00000000, 8'b00000000, 8'b01011110, 8'b00011100,  // 54 hit on strobe 16 R5
        8'b00011100, 8'b00011100, 8'b00011100, 8'b00011100,
        8'b00011100, 8'b00011100, 8'b00011100, 8'b00000000   // 63 watch opens
    };

    function automatic string row_tag(input int i);
        case (i)
            3, 5:            return "R4";
            12, 54:          return "R5";
            29:              return "R6";
            38:              return "R7";
            9, 21, 47, 63:   return "R3";
            default:         return "R2";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(input logic en, input logic st, input logic lim);
        @(negedge clk);
        enable    = en;
        cyc_start = st;
        lim_det   = lim;
        #2;
    endtask

    task automatic sw_cycle(input logic lim0);
        tick(1'b1, 1'b1, lim0);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) tick(1'b1, 1'b1, 1'b0);
        check(hs_inhibit, 1'b0, "R1", "inhibit in reset");
        check(oc_fault, 1'b0, "R1", "fault in reset");
        @(negedge clk);
        rst = 1'b0;
        tick(1'b1, 1'b1, 1'b0);
        check(hs_inhibit, 1'b0, "R1", "inhibit idle strobe");
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] row;
            row = VEC[i];
            ss_active = row[7];
            tick(1'b1, 1'b1, row[6]);
            check(hs_inhibit, row[4], row_tag(i), "inh clk0");
            tick(1'b1, 1'b0, 1'b0);
            check(hs_inhibit, row[3], row_tag(i), "inh clk1");
            check(oc_fault, row[1], row_tag(i), "flt clk1");
            tick(1'b1, 1'b0, row[5]);
            tick(1'b1, 1'b0, 1'b0);
            check(hs_inhibit, row[2], row_tag(i), "inh clk3");
            check(oc_fault, row[0], row_tag(i), "flt clk3");
        end
        ss_active = 1'b0;

        // R8: disable abandons a skip in progress
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        sw_cycle(1'b1);
        check(hs_inhibit, 1'b1, "R2", "inhibit after trip");
        tick(1'b0, 1'b0, 1'b0);
        check(hs_inhibit, 1'b0, "R8", "inhibit while disabled");
        tick(1'b1, 1'b1, 1'b0);
        check(hs_inhibit, 1'b0, "R8", "idle after re-enable");
        tick(1'b1, 1'b0, 1'b0);

        // R2: mid-cycle detect while idle is ignored
        tick(1'b1, 1'b0, 1'b1);
        check(hs_inhibit, 1'b0, "R2", "mid-cycle idle inhibit");
        tick(1'b1, 1'b0, 1'b0);
        check(oc_fault, 1'b0, "R2", "mid-cycle idle fault");
        check(hs_inhibit, 1'b0, "R2", "mid-cycle idle no skip");

        // R1: reset in the middle of a skip
        sw_cycle(1'b1);
        @(negedge clk);
        rst = 1'b1;
        tick(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        tick(1'b1, 1'b1, 1'b0);
        check(hs_inhibit, 1'b0, "R1", "idle after mid-skip reset");
        tick(1'b1, 1'b0, 1'b0);

        // R5 / R9: held detect in window gives one fault clock
        sw_cycle(1'b1);
        for (int k = 0; k < 8; k++) sw_cycle(1'b0);
        tick(1'b1, 1'b1, 1'b0);
        check(hs_inhibit, 1'b0, "R3", "window open");
        tick(1'b1, 1'b0, 1'b1);
        check(oc_fault, 1'b0, "R5", "fault not yet");
        tick(1'b1, 1'b0, 1'b1);
        check(oc_fault, 1'b1, "R5", "fault pulse");
        check(hs_inhibit, 1'b1, "R5", "skip restarted");
        tick(1'b1, 1'b0, 1'b0);
        check(oc_fault, 1'b0, "R9", "fault one clock only");

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule